// File: doc/BRIEF.md
# Serial port status flag controller

This block keeps the status flags of an asynchronous serial port and raises its interrupt request. The transmit and receive datapaths send it one-cycle event strobes. On the transmit side these are "frame with data sent" and "preamble or break sent". On the receive side they are "word ready", with noise and framing qualifiers, and "idle line seen". The bus decoder sends one-cycle strobes for status-register reads and for data-register reads and writes. From these the block keeps six flags, one interrupt request line and a load strobe that tells the receive holding register to capture the incoming word.

A flag is cleared only by a two-step sequence. The first step is a status-register read, which arms the sequencer and takes a snapshot of the flags. The second step is a data-register access. A read clears the receive-side flags that were in the snapshot. A write clears transmit-complete if it was in the snapshot. Either access disarms the sequencer.

When a word arrives while receive-ready is still set, it is an overrun. The held data is kept and the new word is dropped. All pins are plain control and status strobes, so there is no streaming interface and no back-pressure.

Top module: `serial_status_ctrl`

## Requirements
- R1: After reset, the flag vector is 6'b100000 and the interrupt request is 0. The bits are: bit 5 transmit-complete, bit 4 idle, bit 3 framing, bit 2 noise, bit 1 overrun, bit 0 receive-ready. Reset also re-enables idle detection.
- R2: A data-frame-sent strobe sets bit 5 at the next clock edge. A preamble-or-break-sent strobe leaves every flag unchanged.
- R3: Bit 5 is cleared only by a status read followed by a data write. A data read does not clear it, and neither does a data write that has no status read before it.
- R4: Suppose a word-ready strobe arrives while bit 0 is 0. Then hold_load is 1 in that same cycle. At the next edge bit 0 sets, and bits 2 and 3 take the noise and framing qualifiers.
- R5: Suppose a word-ready strobe arrives while bit 0 is 1. Then hold_load stays 0 and bit 1 sets. Bits 2 and 3 are not set, even when the qualifiers are 1.
- R6: A status read followed by a data read clears bits 0 to 4 wherever they were set at the time of the status read. A data write does not clear them.
- R7: A flag that sets after the arming status read is not cleared by the data access that follows.
- R8: When a set event and a clear act on the same flag in the same cycle, the flag ends set.
- R9: An idle strobe sets bit 4. Once bit 4 has been cleared, idle strobes are ignored until a new word has been loaded (a cycle with hold_load = 1).
- R10: irq = (tx_ie AND bit 5) OR (rx_ie AND (bit 0 OR bit 1)) OR (idle_ie AND bit 4). Noise and framing raise no interrupt of their own.
- R11: A data access disarms the sequencer. A second data access that has no new status read before it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_frame_done | input | 1 | Strobe: a frame carrying data finished |
| tx_ctrl_done | input | 1 | Strobe: a preamble or break finished |
| rx_word_rdy | input | 1 | Strobe: a received word is ready to transfer |
| rx_noise | input | 1 | Noise qualifier for rx_word_rdy |
| rx_frame_err | input | 1 | Framing/desync/break qualifier for rx_word_rdy |
| rx_idle | input | 1 | Strobe: an idle line was detected |
| stat_rd | input | 1 | Bus read of the status register |
| data_rd | input | 1 | Bus read of the data register |
| data_wr | input | 1 | Bus write of the data register |
| tx_ie | input | 1 | Transmit-complete interrupt enable |
| rx_ie | input | 1 | Receive and overrun interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| flags | output | 6 | Flag vector (bit map in R1) |
| irq | output | 1 | Interrupt request |
| hold_load | output | 1 | Load strobe for the receive holding register |

## Verification
The bench arms the sequencer and then sets the idle flag before the data read. A design that cleared live flags instead of the snapshot would lose that idle event. It sends a word while receive-ready is set, with the framing qualifier high, and a design that gave framing priority or overwrote the held data would show framing set or pulse hold_load. It sends idle strobes after idle has been cleared, both before and after a new word. This catches a design that re-arms idle detection too early or never re-arms it. It also sends a data-frame strobe in the same cycle as a clearing write, which exposes a design where the clear wins over the set.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int FLAG_W = 6;
  localparam int RXR = 0;
  localparam int OVR = 1;
  localparam int NSE = 2;
  localparam int FER = 3;
  localparam int IDL = 4;
  localparam int TXD = 5;
  localparam int RX_W = IDL + 1;
  localparam int IRQ_SRC = 3;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  localparam flag_vec_t RX_GROUP   = flag_vec_t'((1 << RX_W) - 1);
  localparam flag_vec_t TX_GROUP   = flag_vec_t'(1 << TXD);
  localparam flag_vec_t FLAG_RESET = TX_GROUP;
endpackage

// File: rtl/ssc_clear_seq.sv
module ssc_clear_seq
  import ssc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stat_rd,
  input  logic      data_rd,
  input  logic      data_wr,
  input  flag_vec_t flags_q,
  output flag_vec_t clr_mask
);
  logic      armed_q;
  flag_vec_t snap_q;
  flag_vec_t access_sel;

  always_comb begin
    access_sel = '0;
    if (data_rd) access_sel = access_sel | RX_GROUP;
    if (data_wr) access_sel = access_sel | TX_GROUP;
    clr_mask = armed_q ? (snap_q & access_sel) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      snap_q  <= '0;
    end else if (stat_rd) begin
      armed_q <= 1'b1;
      snap_q  <= flags_q;
    end else if (data_rd || data_wr) begin
      armed_q <= 1'b0;
      snap_q  <= '0;
    end
  end

  // R11
  disarm_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (data_rd || data_wr) && !stat_rd) |=> !armed_q);

  // R7
  clear_within_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~flags_q) == '0));
endmodule

// File: rtl/ssc_rx_flags.sv
module ssc_rx_flags
  import ssc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_rdy,
  input  logic            noise,
  input  logic            frame_err,
  input  logic            idle_evt,
  input  logic [RX_W-1:0] clr,
  output logic [RX_W-1:0] rx_flags,
  output logic            hold_load
);
  logic [RX_W-1:0] flag_q;
  logic [RX_W-1:0] set_v;
  logic            idle_block_q;
  logic            idle_ok;

  assign hold_load = word_rdy && !flag_q[RXR];
  assign idle_ok   = !idle_block_q || hold_load;

  always_comb begin
    set_v      = '0;
    set_v[RXR] = hold_load;
    set_v[OVR] = word_rdy && flag_q[RXR];
    set_v[NSE] = hold_load && noise;
    set_v[FER] = hold_load && frame_err;
    set_v[IDL] = idle_evt && idle_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q       <= '0;
      idle_block_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr) | set_v;
      if (hold_load)
        idle_block_q <= 1'b0;
      else if (clr[IDL] && flag_q[IDL] && !set_v[IDL])
        idle_block_q <= 1'b1;
    end
  end

  assign rx_flags = flag_q;

  // R4
  rx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rdy && !flag_q[RXR]) |=> flag_q[RXR]);

  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rdy && flag_q[RXR]) |=> flag_q[OVR]);

  // R5
  framing_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rdy && flag_q[RXR] && !flag_q[FER]) |=> !flag_q[FER]);
endmodule

// File: rtl/ssc_irq_merge.sv
module ssc_irq_merge #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en,
  output logic            irq
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = src[i] & en[i];
  end

  assign irq = |gated;

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src & en) != '0) |-> irq);
endmodule

// File: rtl/serial_status_ctrl.sv
module serial_status_ctrl
  import ssc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_frame_done,
  input  logic              tx_ctrl_done,
  input  logic              rx_word_rdy,
  input  logic              rx_noise,
  input  logic              rx_frame_err,
  input  logic              rx_idle,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              tx_ie,
  input  logic              rx_ie,
  input  logic              idle_ie,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic              hold_load
);
  flag_vec_t        flags_q;
  flag_vec_t        clr_mask;
  logic [RX_W-1:0]  rx_flags;
  logic             txd_q;
  logic [IRQ_SRC-1:0] irq_src;
  logic [IRQ_SRC-1:0] irq_en;

  ssc_clear_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .flags_q  (flags_q),
    .clr_mask (clr_mask)
  );

  ssc_rx_flags u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_rdy  (rx_word_rdy),
    .noise     (rx_noise),
    .frame_err (rx_frame_err),
    .idle_evt  (rx_idle),
    .clr       (clr_mask[RX_W-1:0]),
    .rx_flags  (rx_flags),
    .hold_load (hold_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) txd_q <= FLAG_RESET[TXD];
    else        txd_q <= (txd_q & ~clr_mask[TXD]) | tx_frame_done;
  end

  assign flags_q = {txd_q, rx_flags};
  assign flags   = flags_q;

  assign irq_src = {rx_flags[IDL], rx_flags[RXR] | rx_flags[OVR], txd_q};
  assign irq_en  = {idle_ie, rx_ie, tx_ie};

  ssc_irq_merge #(.NSRC(IRQ_SRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (irq_src),
    .en    (irq_en),
    .irq   (irq)
  );

  // R2
  ctrl_frame_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ctrl_done && !tx_frame_done && !txd_q) |=> !txd_q);

  // R8
  tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_done |=> txd_q);

  // R3
  tx_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_q && !data_wr) |=> txd_q);
endmodule

// File: tb/serial_status_ctrl_tb_top.sv
module serial_status_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_frame_done = 0, tx_ctrl_done = 0, rx_word_rdy = 0, rx_noise = 0;
  logic rx_frame_err = 0, rx_idle = 0, stat_rd = 0, data_rd = 0, data_wr = 0;
  logic tx_ie = 0, rx_ie = 0, idle_ie = 0;
  logic [5:0] flags;
  logic irq, hold_load;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  serial_status_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_frame_done(tx_frame_done), .tx_ctrl_done(tx_ctrl_done),
    .rx_word_rdy(rx_word_rdy), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
    .rx_idle(rx_idle), .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
    .tx_ie(tx_ie), .rx_ie(rx_ie), .idle_ie(idle_ie),
    .flags(flags), .irq(irq), .hold_load(hold_load)
  );

  // Vector: [23:20] req, [19:8] txf txc rx nz fe idl srd drd dwr ietx ierx ieidle,
  //         [7] hold_load, [6:1] flags after edge, [0] irq after edge
  localparam int NV = 23;
  localparam logic [23:0] VEC [NV] = '{
    {4'd3,  12'b000000100000, 1'b0, 6'b100000, 1'b0}, // R3 arm
    {4'd3,  12'b000000010000, 1'b0, 6'b100000, 1'b0}, // R3 read keeps tx
    {4'd11, 12'b000000001000, 1'b0, 6'b100000, 1'b0}, // R11 unarmed write
    {4'd3,  12'b000000100000, 1'b0, 6'b100000, 1'b0}, // R3 arm
    {4'd3,  12'b000000001000, 1'b0, 6'b000000, 1'b0}, // R3 write clears
    {4'd2,  12'b010000000000, 1'b0, 6'b000000, 1'b0}, // R2 break ignored
    {4'd2,  12'b100000000100, 1'b0, 6'b100000, 1'b1}, // R2 data frame
    {4'd4,  12'b001100000000, 1'b1, 6'b100101, 1'b0}, // R4 load + noise
    {4'd5,  12'b001010000000, 1'b0, 6'b100111, 1'b0}, // R5 overrun beats framing
    {4'd10, 12'b000000000010, 1'b0, 6'b100111, 1'b1}, // R10 rx irq
    {4'd7,  12'b000000100000, 1'b0, 6'b100111, 1'b0}, // R7 arm
    {4'd9,  12'b000001000000, 1'b0, 6'b110111, 1'b0}, // R9 idle sets
    {4'd7,  12'b000000010001, 1'b0, 6'b110000, 1'b1}, // R7 late idle survives
    {4'd6,  12'b000000100000, 1'b0, 6'b110000, 1'b0}, // R6 arm
    {4'd6,  12'b000000010000, 1'b0, 6'b100000, 1'b0}, // R6 idle cleared
    {4'd9,  12'b000001000000, 1'b0, 6'b100000, 1'b0}, // R9 idle blocked
    {4'd4,  12'b001000000000, 1'b1, 6'b100001, 1'b0}, // R4 new word
    {4'd9,  12'b000001000000, 1'b0, 6'b110001, 1'b0}, // R9 idle re-armed
    {4'd6,  12'b000000100000, 1'b0, 6'b110001, 1'b0}, // R6 arm
    {4'd5,  12'b001000010000, 1'b0, 6'b100010, 1'b0}, // R5 word during clear
    {4'd6,  12'b000000100000, 1'b0, 6'b100010, 1'b0}, // R6 arm
    {4'd8,  12'b100000001000, 1'b0, 6'b100010, 1'b0}, // R8 set wins, write keeps rx
    {4'd11, 12'b000000010000, 1'b0, 6'b100010, 1'b0}  // R11 disarmed read
  };

  task automatic check(input int req, input string what, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] s);
    {tx_frame_done, tx_ctrl_done, rx_word_rdy, rx_noise, rx_frame_err, rx_idle,
     stat_rd, data_rd, data_wr, tx_ie, rx_ie, idle_ie} = s;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(1, "reset flags", flags, 6'b100000);
    check(1, "reset irq", {5'b0, irq}, 6'b0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][19:8]);
      #2;
      check(int'(VEC[i][23:20]), "hold_load", {5'b0, hold_load}, {5'b0, VEC[i][7]});
      @(posedge clk);
      #1;
      check(int'(VEC[i][23:20]), "flags", flags, VEC[i][6:1]);
      check(int'(VEC[i][23:20]), "irq", {5'b0, irq}, {5'b0, VEC[i][0]});
    end
    // R1 mid-run reset restores flags and re-enables idle detection
    @(negedge clk);
    drive(12'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(1, "reset flags again", flags, 6'b100000);
    @(negedge clk);
    drive(12'b000001000001);
    @(posedge clk);
    #1;
    check(1, "idle after reset", flags, 6'b110000);
    check(10, "idle irq", {5'b0, irq}, 6'b000001);
    @(negedge clk);
    drive(12'b0);
    #1;
    check(10, "irq disabled", {5'b0, irq}, 6'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule